// File: doc/BRIEF.md
# Accumulator Machine Sequencer

This block is the hardwired control unit of a small accumulator computer. Each instruction is 16 bits wide. The upper three bits are the operation code and the lower thirteen bits are a memory address. The block holds a state register, next-state logic and separate output decoding. It steps the machine through a common fetch sequence and then a short execute sequence chosen by the opcode. In every state it raises exactly one transfer strobe, and the datapath around it acts on that strobe at the next rising edge.

The block takes the opcode from the instruction register and two status flags from the accumulator: one for zero and one for the sign bit. The conditional skip and the conditional branch look only at these two flags. The program counter, the address and data registers, the accumulator, the ALU and the memory are outside the block.

Top module: `acc_ctrl_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the only strobe raised is `pc_to_mar`. Reset is synchronous and active high.
- R2: Fetch raises `pc_to_mar`, `pc_inc`, `mem_rd` and `mdr_to_ir`, in that order, on consecutive cycles.
- R3: The cycle after `mdr_to_ir` always raises `ir_to_mar`, whatever the opcode. The opcode encoding is load=000, store=001, add=010, and=011, skip=100, jump=101, jump-if-negative=110 and 111 unused.
- R4: After `ir_to_mar`, opcode load raises `mem_rd`, `acc_clr` and `alu_add` on consecutive cycles, and then fetch begins again.
- R5: After `ir_to_mar`, opcode add raises `mem_rd` then `alu_add`, and opcode and raises `mem_rd` then `alu_and`. Fetch follows in both cases.
- R6: After `ir_to_mar`, opcode store raises `acc_to_mdr` then `mem_wr`, and then fetch begins again.
- R7: After `ir_to_mar`, opcode skip raises one extra `pc_inc` when the accumulator is greater than zero (`acc_zero`=0 and `acc_neg`=0). Otherwise fetch starts directly.
- R8: After `ir_to_mar`, opcode jump always raises `pc_load`. Opcode jump-if-negative raises `pc_load` only when `acc_neg`=1 and otherwise starts fetch directly.
- R9: Opcode 111 raises no strobe after `ir_to_mar`, and the next cycle is `pc_to_mar`.
- R10: Out of reset, exactly one of the eleven strobes is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 3 | Opcode field of the instruction register |
| acc_zero | input | 1 | Accumulator equals zero |
| acc_neg | input | 1 | Accumulator sign bit |
| pc_to_mar | output | 1 | Copy program counter to memory address register |
| ir_to_mar | output | 1 | Copy instruction address field to memory address register |
| pc_inc | output | 1 | Increment program counter |
| mem_rd | output | 1 | Read memory into memory data register |
| mem_wr | output | 1 | Write memory data register to memory |
| mdr_to_ir | output | 1 | Copy memory data register to instruction register |
| acc_clr | output | 1 | Clear accumulator |
| alu_add | output | 1 | Accumulator gets memory data plus accumulator |
| alu_and | output | 1 | Accumulator gets memory data AND accumulator |
| acc_to_mdr | output | 1 | Copy accumulator to memory data register |
| pc_load | output | 1 | Load program counter from instruction address field |

## Verification
The block is built with its package defaults: a 3-bit opcode and a 4-bit state code. The bench also uses a 13-bit address field, of which a 64-word model memory decodes the low six bits. With these values, a short program around a behavioural datapath reaches every opcode, including the unused code. Both branch decisions are taken and not taken, and the skip meets a positive, a zero and a negative accumulator. Every strobe is compared each cycle against a queue-based model, and the final memory and accumulator contents confirm the data effects.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

    localparam int OPC_W   = 3;
    localparam int STATE_W = 4;
    localparam int N_STROBE = 11;

    localparam logic [OPC_W-1:0] OP_LOAD  = 3'b000;
    localparam logic [OPC_W-1:0] OP_STORE = 3'b001;
    localparam logic [OPC_W-1:0] OP_ADD   = 3'b010;
    localparam logic [OPC_W-1:0] OP_AND   = 3'b011;
    localparam logic [OPC_W-1:0] OP_SKIP  = 3'b100;
    localparam logic [OPC_W-1:0] OP_JUMP  = 3'b101;
    localparam logic [OPC_W-1:0] OP_JNEG  = 3'b110;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH_ADDR  = 4'd0,
        ST_FETCH_INC   = 4'd1,
        ST_FETCH_READ  = 4'd2,
        ST_FETCH_IR    = 4'd3,
        ST_OPER_ADDR   = 4'd4,
        ST_OPER_READ   = 4'd5,
        ST_LOAD_CLEAR  = 4'd6,
        ST_SUM         = 4'd7,
        ST_MASK        = 4'd8,
        ST_STORE_STAGE = 4'd9,
        ST_STORE_WRITE = 4'd10,
        ST_SKIP_INC    = 4'd11,
        ST_BRANCH      = 4'd12,
        ST_IDLE_OP     = 4'd13
    } ctrl_state_e;

    typedef struct packed {
        logic pc_load;
        logic acc_to_mdr;
        logic alu_and;
        logic alu_add;
        logic acc_clr;
        logic mdr_to_ir;
        logic mem_wr;
        logic mem_rd;
        logic pc_inc;
        logic ir_to_mar;
        logic pc_to_mar;
    } ctrl_strobes_t;

    typedef struct packed {
        logic zero;
        logic neg;
    } acc_flags_t;

    function automatic logic acc_positive(input acc_flags_t f);
        return !f.zero && !f.neg;
    endfunction

endpackage

// File: rtl/acc_ctrl_next.sv
module acc_ctrl_next
    import acc_ctrl_pkg::*;
(
    input  ctrl_state_e          cur,
    input  logic [OPC_W-1:0]     opcode,
    input  acc_flags_t           flags,
    output ctrl_state_e          nxt
);
    always_comb begin
        nxt = ST_FETCH_ADDR;
        unique case (cur)
            ST_FETCH_ADDR: nxt = ST_FETCH_INC;
            ST_FETCH_INC:  nxt = ST_FETCH_READ;
            ST_FETCH_READ: nxt = ST_FETCH_IR;
            ST_FETCH_IR:   nxt = ST_OPER_ADDR;
            ST_OPER_ADDR: begin
                case (opcode)
                    OP_LOAD, OP_ADD, OP_AND: nxt = ST_OPER_READ;
                    OP_STORE: nxt = ST_STORE_STAGE;
                    OP_SKIP:  nxt = acc_positive(flags) ? ST_SKIP_INC : ST_FETCH_ADDR;
                    OP_JUMP:  nxt = ST_BRANCH;
                    OP_JNEG:  nxt = flags.neg ? ST_BRANCH : ST_FETCH_ADDR;
                    default:  nxt = ST_FETCH_ADDR;
                endcase
            end
            ST_OPER_READ: begin
                case (opcode)
                    OP_LOAD: nxt = ST_LOAD_CLEAR;
                    OP_ADD:  nxt = ST_SUM;
                    OP_AND:  nxt = ST_MASK;
                    default: nxt = ST_FETCH_ADDR;
                endcase
            end
            ST_LOAD_CLEAR:  nxt = ST_SUM;
            ST_STORE_STAGE: nxt = ST_STORE_WRITE;
            default:        nxt = ST_FETCH_ADDR;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
    import acc_ctrl_pkg::*;
(
    input  ctrl_state_e   cur,
    output ctrl_strobes_t strobes
);
    always_comb begin
        strobes = '0;
        case (cur)
            ST_FETCH_ADDR:  strobes.pc_to_mar  = 1'b1;
            ST_FETCH_INC:   strobes.pc_inc     = 1'b1;
            ST_FETCH_READ:  strobes.mem_rd     = 1'b1;
            ST_FETCH_IR:    strobes.mdr_to_ir  = 1'b1;
            ST_OPER_ADDR:   strobes.ir_to_mar  = 1'b1;
            ST_OPER_READ:   strobes.mem_rd     = 1'b1;
            ST_LOAD_CLEAR:  strobes.acc_clr    = 1'b1;
            ST_SUM:         strobes.alu_add    = 1'b1;
            ST_MASK:        strobes.alu_and    = 1'b1;
            ST_STORE_STAGE: strobes.acc_to_mdr = 1'b1;
            ST_STORE_WRITE: strobes.mem_wr     = 1'b1;
            ST_SKIP_INC:    strobes.pc_inc     = 1'b1;
            ST_BRANCH:      strobes.pc_load    = 1'b1;
            default:        strobes            = '0;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_top.sv
module acc_ctrl_top
    import acc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       opcode,
    input  logic             acc_zero,
    input  logic             acc_neg,
    output logic             pc_to_mar,
    output logic             ir_to_mar,
    output logic             pc_inc,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mdr_to_ir,
    output logic             acc_clr,
    output logic             alu_add,
    output logic             alu_and,
    output logic             acc_to_mdr,
    output logic             pc_load
);
    ctrl_state_e   state_q;
    ctrl_state_e   state_d;
    ctrl_strobes_t strobes;
    acc_flags_t    flags;

    assign flags.zero = acc_zero;
    assign flags.neg  = acc_neg;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_ADDR;
        else     state_q <= state_d;
    end

    acc_ctrl_next u_next (
        .cur    (state_q),
        .opcode (opcode),
        .flags  (flags),
        .nxt    (state_d)
    );

    acc_ctrl_decode u_decode (
        .cur     (state_q),
        .strobes (strobes)
    );

    assign pc_to_mar  = strobes.pc_to_mar;
    assign ir_to_mar  = strobes.ir_to_mar;
    assign pc_inc     = strobes.pc_inc;
    assign mem_rd     = strobes.mem_rd;
    assign mem_wr     = strobes.mem_wr;
    assign mdr_to_ir  = strobes.mdr_to_ir;
    assign acc_clr    = strobes.acc_clr;
    assign alu_add    = strobes.alu_add;
    assign alu_and    = strobes.alu_and;
    assign acc_to_mdr = strobes.acc_to_mdr;
    assign pc_load    = strobes.pc_load;
endmodule

// File: rtl/acc_ctrl_checker.sv
module acc_ctrl_checker
    import acc_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] opcode,
    input logic       acc_zero,
    input logic       acc_neg,
    input logic       pc_to_mar,
    input logic       ir_to_mar,
    input logic       pc_inc,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mdr_to_ir,
    input logic       acc_clr,
    input logic       alu_add,
    input logic       alu_and,
    input logic       acc_to_mdr,
    input logic       pc_load
);
    logic [N_STROBE-1:0] all_strobes;
    assign all_strobes = {pc_load, acc_to_mdr, alu_and, alu_add, acc_clr,
                          mdr_to_ir, mem_wr, mem_rd, pc_inc, ir_to_mar, pc_to_mar};

    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_to_mar);

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        pc_to_mar |=> pc_inc);

    assert_exec_entry_R3: assert property (@(posedge clk) disable iff (rst)
        mdr_to_ir |=> ir_to_mar);

    assert_clear_then_add_R4: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> alu_add);

    assert_store_pair_R6: assert property (@(posedge clk) disable iff (rst)
        acc_to_mdr |=> mem_wr);

    assert_skip_cond_R7: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && $past(ir_to_mar)) |-> ($past(opcode) == OP_SKIP && !$past(acc_zero) && !$past(acc_neg)));

    assert_branch_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (pc_load && $past(opcode) == OP_JNEG) |-> $past(acc_neg));

    assert_back_to_fetch_R8: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> pc_to_mar);

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(all_strobes) == 1);
endmodule

bind acc_ctrl_top acc_ctrl_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .acc_zero   (acc_zero),
    .acc_neg    (acc_neg),
    .pc_to_mar  (pc_to_mar),
    .ir_to_mar  (ir_to_mar),
    .pc_inc     (pc_inc),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mdr_to_ir  (mdr_to_ir),
    .acc_clr    (acc_clr),
    .alu_add    (alu_add),
    .alu_and    (alu_and),
    .acc_to_mdr (acc_to_mdr),
    .pc_load    (pc_load)
);

// File: tb/tb_acc_ctrl_top.sv
module tb_acc_ctrl_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        pc_to_mar, ir_to_mar, pc_inc, mem_rd, mem_wr, mdr_to_ir;
    logic        acc_clr, alu_add, alu_and, acc_to_mdr, pc_load;
    logic [15:0] mem [64];
    logic [12:0] pc, mar;
    logic [15:0] ir, mdr, acc;
    logic        acc_zero, acc_neg;

    assign acc_zero = (acc == 16'd0);
    assign acc_neg  = acc[15];

    acc_ctrl_top dut (
        .clk(clk), .rst(rst), .opcode(ir[15:13]),
        .acc_zero(acc_zero), .acc_neg(acc_neg),
        .pc_to_mar(pc_to_mar), .ir_to_mar(ir_to_mar), .pc_inc(pc_inc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mdr_to_ir(mdr_to_ir),
        .acc_clr(acc_clr), .alu_add(alu_add), .alu_and(alu_and),
        .acc_to_mdr(acc_to_mdr), .pc_load(pc_load)
    );

    // one-hot codes, bit order: pc_to_mar=0 .. pc_load=10
    localparam logic [10:0] E_PCMAR = 11'd1 << 0;
    localparam logic [10:0] E_IRMAR = 11'd1 << 1;
    localparam logic [10:0] E_INC   = 11'd1 << 2;
    localparam logic [10:0] E_RD    = 11'd1 << 3;
    localparam logic [10:0] E_WR    = 11'd1 << 4;
    localparam logic [10:0] E_IR    = 11'd1 << 5;
    localparam logic [10:0] E_CLR   = 11'd1 << 6;
    localparam logic [10:0] E_ADD   = 11'd1 << 7;
    localparam logic [10:0] E_AND   = 11'd1 << 8;
    localparam logic [10:0] E_A2M   = 11'd1 << 9;
    localparam logic [10:0] E_LOAD  = 11'd1 << 10;

    logic [10:0] obs;
    assign obs = {pc_load, acc_to_mdr, alu_and, alu_add, acc_clr,
                  mdr_to_ir, mem_wr, mem_rd, pc_inc, ir_to_mar, pc_to_mar};

    // behavioural datapath driven by the strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0; mar <= '0; ir <= '0; mdr <= '0; acc <= '0;
        end else begin
            if (pc_to_mar)  mar <= pc;
            if (ir_to_mar)  mar <= ir[12:0];
            if (pc_inc)     pc  <= pc + 13'd1;
            if (pc_load)    pc  <= ir[12:0];
            if (mem_rd)     mdr <= mem[mar[5:0]];
            if (mem_wr)     mem[mar[5:0]] <= mdr;
            if (mdr_to_ir)  ir  <= mdr;
            if (acc_clr)    acc <= '0;
            if (alu_add)    acc <= acc + mdr;
            if (alu_and)    acc <= acc & mdr;
            if (acc_to_mdr) mdr <= acc;
        end
    end

    int checks = 0;
    int failures = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [10:0] s, input string t);
        exp_q.push_back(s);
        tag_q.push_back(t);
    endtask

    function automatic logic [15:0] ins(input logic [2:0] op, input int a);
        return {op, 13'(a)};
    endfunction

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'd0;
        mem[0]  = ins(3'b000, 20);   // acc=5
        mem[1]  = ins(3'b010, 21);   // acc=8
        mem[2]  = ins(3'b100, 0);    // positive: skip 3
        mem[3]  = ins(3'b101, 0);
        mem[4]  = ins(3'b011, 22);   // acc=8&12=8
        mem[5]  = ins(3'b001, 23);   // mem23=8
        mem[6]  = ins(3'b000, 24);   // acc=-2
        mem[7]  = ins(3'b100, 0);    // negative: no skip
        mem[8]  = ins(3'b110, 10);   // taken
        mem[9]  = ins(3'b111, 0);    // jumped over
        mem[10] = ins(3'b111, 0);    // unused opcode
        mem[11] = ins(3'b000, 25);   // acc=0
        mem[12] = ins(3'b100, 0);    // zero: no skip
        mem[13] = ins(3'b110, 30);   // not taken
        mem[14] = ins(3'b010, 21);   // acc=3
        mem[15] = ins(3'b110, 0);    // not taken
        mem[16] = ins(3'b101, 16);   // loop
        mem[20] = 16'd5;
        mem[21] = 16'd3;
        mem[22] = 16'h000C;
        mem[24] = 16'hFFFE;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset strobe", {5'd0, obs}, {5'd0, E_PCMAR});
        rst = 1'b0;
        push(E_INC, "R2"); push(E_RD, "R2"); push(E_IR, "R2"); push(E_IRMAR, "R3");

        for (int cyc = 0; cyc < 400; cyc++) begin
            logic [10:0] e;
            string t;
            @(negedge clk);
            if (exp_q.size() == 0) begin
                push(E_PCMAR, "R2"); push(E_INC, "R2"); push(E_RD, "R2");
                push(E_IR, "R2"); push(E_IRMAR, "R3");
            end
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e == E_IRMAR) begin
                case (ir[15:13])
                    3'b000: begin push(E_RD, "R4"); push(E_CLR, "R4"); push(E_ADD, "R4"); end
                    3'b001: begin push(E_A2M, "R6"); push(E_WR, "R6"); end
                    3'b010: begin push(E_RD, "R5"); push(E_ADD, "R5"); end
                    3'b011: begin push(E_RD, "R5"); push(E_AND, "R5"); end
                    3'b100: if (acc != 16'd0 && !acc[15]) push(E_INC, "R7");
                    3'b101: push(E_LOAD, "R8");
                    3'b110: if (acc[15]) push(E_LOAD, "R8");
                    default: ;
                endcase
            end
            check({t, " strobe"}, {5'd0, obs}, {5'd0, e});
            check("R10 single strobe", 16'($countones(obs)), 16'd1);
        end

        @(negedge clk);
        check("R6 stored word", mem[23], 16'd8);
        check("R5 final accumulator", acc, 16'd3);
        check("R8 pc in final loop", {15'd0, (pc == 13'd16 || pc == 13'd17)}, 16'd1);
        check("R9 unused opcode left memory", mem[9], ins(3'b111, 0));
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule